// File: doc/BRIEF.md
# Noise Alarm Timer

This block watches a receive channel for activity that keeps arriving but never satisfies the output-enable qualification filter. Such activity points to noise rather than a real transmission. A counter advances on a slow 32 kHz tick enable while an unqualified signal is present. If that condition persists for the full timeout (1024 ticks, about 32 ms), the block raises an alarm.

The alarm drives an active-low alert pin and latches a status flag. A host that sees the pin can react, for example by lowering channel sensitivity. It then clears the flag by pulsing a status-read strobe. Several events restart the count: a chip-select access, disabling the filter, a filter pass, or loss of the signal. While the filter is disabled the timer stays idle.

Top module: `noise_alarm_timer`

## Requirements
- R1: After reset, `alert_n` is 1 and `alarm_flag` is 0.
- R2: While the channel is active (`sig_present`=1, `filt_en`=1, `filt_pass`=0, `cs_n`=1), each clock edge with `tick`=1 adds one to the count. The 1024th such tick sets `alarm_flag` to 1 and `alert_n` to 0 on that same edge. After 1023 ticks both outputs are still idle.
- R3: A clock edge with `cs_n`=0 clears the count, so a full 1024 further active ticks are needed to reach the alarm.
- R4: A clock edge with `filt_en`=0 clears the count. No alarm can occur while the filter stays disabled, whatever the tick count.
- R5: A clock edge with `filt_pass`=1 clears the count.
- R6: A clock edge with `sig_present`=0 clears the count, and counting restarts from zero when the signal returns.
- R7: `alarm_flag` stays set until a clock edge with `stat_rd`=1. That edge clears the flag and returns `alert_n` to 1 at the same time.
- R8: While the alarm is set the count does not advance. After a read clears the alarm, a continuing unqualified signal needs a full 1024 new ticks to raise it again.
- R9: Clock edges with `tick`=0 never advance the count, however many occur.
- R10: With the default priority, if `stat_rd`=1 on the same edge as the 1024th tick, the read wins. The flag stays 0 and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 32 kHz tick enable |
| sig_present | input | 1 | Input signal is being received |
| filt_en | input | 1 | Output-enable qualification filter is enabled |
| filt_pass | input | 1 | Signal has passed the filter, so the data output is enabled |
| cs_n | input | 1 | Active-low chip select; low means a host access |
| stat_rd | input | 1 | Host status-read strobe; clears the alarm |
| alert_n | output | 1 | Active-low alert pin |
| alarm_flag | output | 1 | Sticky alarm status bit |

## Verification
The hardest situation to reach from the ports is a status read that lands on exactly the edge that carries the 1024th qualifying tick. Tests based on a free-running tick cannot line the two up reliably. The bench therefore drives every tick itself, one pulse at a time. It counts 1023 pulses, then raises the read strobe and the final tick together in one cycle. It also places clears one tick short of expiry, which shows that each clear forces a complete new window.

// File: rtl/nat_pkg.sv
package nat_pkg;
   // Resolution when the host read and a fresh expiry share one edge
   typedef enum logic [0:0] {
      PRIO_READ_WINS = 1'b0,
      PRIO_SET_WINS  = 1'b1
   } nat_prio_e;

   function automatic int nat_cnt_width(input int ticks);
      return (ticks < 2) ? 1 : $clog2(ticks);
   endfunction
endpackage

// File: rtl/nat_qualify.sv
module nat_qualify (
   input  logic sig_present,
   input  logic filt_en,
   input  logic filt_pass,
   input  logic cs_n,
   input  logic alarm_on,
   output logic clr,
   output logic run
);
   logic active;

   // Unqualified activity: signal seen, filter armed, no pass, no host access
   always_comb begin
      active = sig_present & filt_en & ~filt_pass & cs_n;
      clr    = ~active;
      run    = active & ~alarm_on;
   end
endmodule

// File: rtl/nat_window_counter.sv
module nat_window_counter #(
   parameter int TIMEOUT_TICKS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic tick,
   output logic expire
);
   localparam int CNT_W = nat_pkg::nat_cnt_width(TIMEOUT_TICKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

   generate
      if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
         $error("TIMEOUT_TICKS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             at_last;

   always_comb begin
      at_last = (cnt == LAST);
      expire  = ~clr & run & tick & at_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (run && tick) begin
         if (at_last) cnt <= '0;
         else         cnt <= cnt + 1'b1;
      end
   end

   a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt));
   a_r8_frozen_when_alarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt));
   a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   a_r2_wrap_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == '0));
endmodule

// File: rtl/nat_alarm_latch.sv
module nat_alarm_latch #(
   parameter nat_pkg::nat_prio_e PRIO = nat_pkg::PRIO_READ_WINS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic rd,
   output logic flag
);
   logic flag_d;

   generate
      if (PRIO == nat_pkg::PRIO_READ_WINS) begin : g_read_wins
         always_comb begin
            if (rd)       flag_d = 1'b0;
            else if (set) flag_d = 1'b1;
            else          flag_d = flag;
         end
         a_r10_read_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
            rd |=> !flag);
      end else begin : g_set_wins
         always_comb begin
            if (set)     flag_d = 1'b1;
            else if (rd) flag_d = 1'b0;
            else         flag_d = flag;
         end
         a_r10_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
            set |=> flag);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag_d;
   end

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !rd) |=> flag);
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !set) |=> !flag);
   a_r2_only_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !set) |=> !flag);
endmodule

// File: rtl/noise_alarm_timer.sv
module noise_alarm_timer #(
   parameter int                 TIMEOUT_TICKS = 1024,
   parameter nat_pkg::nat_prio_e PRIO          = nat_pkg::PRIO_READ_WINS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sig_present,
   input  logic filt_en,
   input  logic filt_pass,
   input  logic cs_n,
   input  logic stat_rd,
   output logic alert_n,
   output logic alarm_flag
);
   logic clr;
   logic run;
   logic expire;
   logic alarm_q;

   nat_qualify u_qualify (
      .sig_present (sig_present),
      .filt_en     (filt_en),
      .filt_pass   (filt_pass),
      .cs_n        (cs_n),
      .alarm_on    (alarm_q),
      .clr         (clr),
      .run         (run)
   );

   nat_window_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .run    (run),
      .tick   (tick),
      .expire (expire)
   );

   nat_alarm_latch #(.PRIO(PRIO)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (expire),
      .rd    (stat_rd),
      .flag  (alarm_q)
   );

   assign alarm_flag = alarm_q;
   assign alert_n    = ~alarm_q;

   a_r4_no_alarm_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!filt_en && !alarm_q) |=> !alarm_flag);
   a_r8_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_q |-> !expire);
endmodule

// File: tb/noise_alarm_timer_test.sv
`timescale 1ns/1ps
module noise_alarm_timer_test;
   localparam int LIMIT = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, sig_present = 1'b0, filt_en = 1'b0, filt_pass = 1'b0;
   logic cs_n = 1'b1, stat_rd = 1'b0;
   logic alert_n, alarm_flag;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   // reference model state
   int m_cnt   = 0;
   bit m_alarm = 1'b0;

   always #4 clk = ~clk;

   noise_alarm_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sig_present(sig_present),
      .filt_en(filt_en), .filt_pass(filt_pass), .cs_n(cs_n), .stat_rd(stat_rd),
      .alert_n(alert_n), .alarm_flag(alarm_flag)
   );

   // behavioural reference: one update per clock edge
   always @(posedge clk) begin
      bit fire;
      fire = 1'b0;
      if (!rst_n) begin
         m_cnt   = 0;
         m_alarm = 1'b0;
      end else begin
         if (!(sig_present && filt_en && !filt_pass && cs_n)) m_cnt = 0;
         else if (tick && !m_alarm) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == LIMIT) begin
               m_cnt = 0;
               fire  = 1'b1;
            end
         end
         if (stat_rd)   m_alarm = 1'b0;
         else if (fire) m_alarm = 1'b1;
      end
      cycles = cycles + 1;
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_tests = n_tests + 1;
         if (alarm_flag !== m_alarm || alert_n !== !m_alarm) begin
            n_fail = n_fail + 1;
            $display("FAIL R2 per-cycle model: flag=%0b alert_n=%0b expected flag=%0b alert_n=%0b",
                     alarm_flag, alert_n, m_alarm, !m_alarm);
         end
      end
   end

   task automatic chk(input string tag, input bit exp_flag);
      n_tests = n_tests + 1;
      if (alarm_flag !== exp_flag || alert_n !== !exp_flag) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: flag=%0b alert_n=%0b expected flag=%0b alert_n=%0b",
                  tag, alarm_flag, alert_n, exp_flag, !exp_flag);
      end
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic read_pulse();
      @(negedge clk) stat_rd = 1'b1;
      @(negedge clk) stat_rd = 1'b0;
   endtask

   task automatic go_active();
      @(negedge clk);
      sig_present = 1'b1; filt_en = 1'b1; filt_pass = 1'b0; cs_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 1'b0);

      // R2 basic expiry
      go_active();
      pulses(LIMIT - 1);
      chk("R2 one tick short", 1'b0);
      pulses(1);
      chk("R2 expiry", 1'b1);

      // R7 sticky, then read clears
      pulses(50);
      repeat (20) @(negedge clk);
      chk("R7 held without read", 1'b1);
      read_pulse();
      chk("R7 read clears flag and pin", 1'b0);

      // R8 full new window after read
      pulses(LIMIT - 1);
      chk("R8 no early refire", 1'b0);
      pulses(1);
      chk("R8 refire after full window", 1'b1);
      read_pulse();

      // R3 chip select clears
      pulses(LIMIT - 1);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) cs_n = 1'b1;
      pulses(LIMIT - 1);
      chk("R3 cs clear restarts window", 1'b0);
      pulses(1);
      chk("R3 expiry after cs clear", 1'b1);
      read_pulse();

      // R5 filter pass clears
      pulses(LIMIT - 1);
      @(negedge clk) filt_pass = 1'b1;
      @(negedge clk) filt_pass = 1'b0;
      pulses(LIMIT - 1);
      chk("R5 pass clear restarts window", 1'b0);
      pulses(1);
      chk("R5 expiry after pass clear", 1'b1);
      read_pulse();

      // R6 signal drop clears
      pulses(LIMIT - 1);
      @(negedge clk) sig_present = 1'b0;
      pulses(3);
      @(negedge clk) sig_present = 1'b1;
      pulses(LIMIT - 1);
      chk("R6 signal loss restarts window", 1'b0);
      pulses(1);
      chk("R6 expiry after signal returns", 1'b1);
      read_pulse();

      // R4 filter disabled: inactive over a long stretch
      pulses(LIMIT - 1);
      @(negedge clk) filt_en = 1'b0;
      pulses(2 * LIMIT + 10);
      chk("R4 no alarm while filter disabled", 1'b0);
      @(negedge clk) filt_en = 1'b1;
      pulses(LIMIT - 1);
      chk("R4 window restarts on enable", 1'b0);
      pulses(1);
      chk("R4 expiry after enable", 1'b1);
      read_pulse();

      // R9 cycles without tick never count
      pulses(LIMIT - 1);
      repeat (5000) @(negedge clk);
      chk("R9 idle cycles do not count", 1'b0);
      pulses(1);
      chk("R9 last tick expires", 1'b1);
      read_pulse();

      // R10 read on the expiry edge wins
      pulses(LIMIT - 1);
      @(negedge clk) begin tick = 1'b1; stat_rd = 1'b1; end
      @(negedge clk) begin tick = 1'b0; stat_rd = 1'b0; end
      chk("R10 read beats expiry", 1'b0);
      pulses(LIMIT - 1);
      chk("R10 window restarted", 1'b0);
      pulses(1);
      chk("R10 later expiry", 1'b1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // watchdog
   initial begin
      wait (cycles >= 200000);
      if (!done) begin
         done    = 1'b1;
         n_tests = n_tests + 1;
         n_fail  = n_fail + 1;
         $display("FAIL watchdog: run did not finish, cycles=%0d expected below 200000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule